// File: doc/BRIEF.md
# Single-Wire Debug Bit Engine

This block times individual bits on a single open-drain style debug line. The remote host starts every bit by pulling the line low. The engine sees that falling edge through an input synchronizer and then counts system clock cycles from it. In receive mode it samples the line at a fixed offset and reports the level. In transmit mode it either leaves the line floating, for a one, or holds it low, for a zero. Either way it finishes the bit with a single-cycle active-high drive that speeds up the rising edge, and then releases the line again.

A higher layer passes in one bit to send at a time through a valid/ready handshake, or raises a receive request. The engine arms edge detection only after it has accepted one of these. Each received bit comes back as a level with a one-cycle valid pulse. The line itself is brought out as a driven level plus an output enable. Framing, command handling and timeouts are left to the surrounding logic.

Top module: `dbg_bit_engine`

## Requirements
- R1: The line input passes through a two-flop synchronizer. An edge counts only in an armed cycle where the synchronized level is 0 and was 1 in the previous cycle. That cycle is called E. A host pull-down that first appears on `pin_i` in cycle h gives E = h+2.
- R2: While idle, `tx_ready_o` is 1 and `pin_oe_o` is 0. When `tx_valid_i` and `tx_ready_o` are both 1, the engine takes `tx_bit_i` and arms. Otherwise, when `rx_req_i` is 1, it arms for receive. Transmit wins when both are asserted. `tx_ready_o` stays 0 until the bit finishes.
- R3: Receive: `rx_valid_o` is 1 for exactly cycle E+13, and `rx_bit_o` then carries the synchronized line level of cycle E+12. The engine is idle again in cycle E+13.
- R4: Transmit of 1: `pin_oe_o` stays 0 through cycle E+6. In cycle E+7 the engine drives `pin_oe_o`=1 and `pin_o`=1. From E+8 the line is released and `tx_ready_o` is 1.
- R5: Transmit of 0: from E+1 to E+9 the engine drives `pin_oe_o`=1 and `pin_o`=0, which is 9 cycles. In E+10 it drives `pin_o`=1. From E+11 the line is released and `tx_ready_o` is 1.
- R6: Falling edges have no effect while the engine is idle or while a bit is in progress.
- R7: `pin_oe_o` is 1 only in the windows of R4 and R5. `pin_o` is 0 whenever `pin_oe_o` is 0. `rx_valid_o` is 1 only as stated in R3.
- R8: A synchronous active-high reset gives `pin_oe_o`=0, `pin_o`=0, `rx_valid_o`=0 and `tx_ready_o`=1 in the following cycle, even in the middle of a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the bit |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw level seen on the debug line |
| pin_o | output | 1 | Level driven when the output is enabled |
| pin_oe_o | output | 1 | Output driver enable (0 = high impedance) |
| tx_bit_i | input | 1 | Bit to transmit |
| tx_valid_i | input | 1 | Transmit bit is offered |
| tx_ready_o | output | 1 | Engine idle and able to take a bit |
| rx_req_i | input | 1 | Request to receive one bit |
| rx_bit_o | output | 1 | Received bit level |
| rx_valid_o | output | 1 | One-cycle pulse marking `rx_bit_o` valid |

## Verification
The hardest cases to reach from the ports are a host edge that lands while no bit is armed, and a second edge that lands in the middle of a bit. Neither one changes the outputs right away. The bench therefore pulses the line while the engine is idle, then raises a receive request with the line held high and confirms that no bit is ever reported. It also pulls the line low again during a zero transmission and counts the low-drive cycles, which must stay at exactly nine. A reset placed in the middle of a low drive and a cycle in which both requests are asserted together complete the set of corner cases.

// File: rtl/dbg_bit_pkg.sv
package dbg_bit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_TIME,
        ST_PULSE
    } eng_state_t;

    typedef enum logic [1:0] {
        BM_RECV,
        BM_SEND1,
        BM_SEND0
    } bit_mode_t;

    typedef struct packed {
        logic oe;
        logic lvl;
    } drive_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level_o;
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~level_o;
endmodule

// File: rtl/dbg_bit_timer.sv
module dbg_bit_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [CW-1:0] limit_i,
    output logic          hit_o
);
    logic [CW-1:0] cnt_q;

    assign hit_o = (cnt_q != '0) && (cnt_q == limit_i);

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start_i)       cnt_q <= CW'(1);
        else if (hit_o)         cnt_q <= '0;
        else if (cnt_q != '0)   cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/dbg_bit_engine.sv
module dbg_bit_engine
    import dbg_bit_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RX_WAIT     = 12,
    parameter int unsigned TX1_FLOAT   = 6,
    parameter int unsigned TX0_LOW     = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic pin_o,
    output logic pin_oe_o,
    input  logic tx_bit_i,
    input  logic tx_valid_i,
    output logic tx_ready_o,
    input  logic rx_req_i,
    output logic rx_bit_o,
    output logic rx_valid_o
);
    localparam int unsigned MAXC = max3(RX_WAIT, TX1_FLOAT, TX0_LOW);
    localparam int unsigned CW   = $clog2(MAXC + 1);

    eng_state_t    st_q;
    bit_mode_t     mode_q;
    drive_t        drv_q;
    logic          rxv_q, rxb_q;
    logic          pin_s, pin_fall, start, hit;
    logic [CW-1:0] limit;

    dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_i),
        .level_o(pin_s), .fall_o(pin_fall)
    );

    dbg_bit_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .start_i(start),
        .limit_i(limit), .hit_o(hit)
    );

    assign start = (st_q == ST_ARM) && pin_fall;

    always_comb begin
        unique case (mode_q)
            BM_SEND1: limit = CW'(TX1_FLOAT);
            BM_SEND0: limit = CW'(TX0_LOW);
            default:  limit = CW'(RX_WAIT);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= BM_RECV;
            drv_q  <= '0;
            rxv_q  <= 1'b0;
            rxb_q  <= 1'b0;
        end else begin
            rxv_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (tx_valid_i) begin
                        mode_q <= tx_bit_i ? BM_SEND1 : BM_SEND0;
                        st_q   <= ST_ARM;
                    end else if (rx_req_i) begin
                        mode_q <= BM_RECV;
                        st_q   <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (pin_fall) begin
                        st_q <= ST_TIME;
                        if (mode_q == BM_SEND0) drv_q <= '{oe: 1'b1, lvl: 1'b0};
                    end
                end
                ST_TIME: begin
                    if (hit) begin
                        if (mode_q == BM_RECV) begin
                            rxv_q <= 1'b1;
                            rxb_q <= pin_s;
                            st_q  <= ST_IDLE;
                        end else begin
                            drv_q <= '{oe: 1'b1, lvl: 1'b1};
                            st_q  <= ST_PULSE;
                        end
                    end
                end
                ST_PULSE: begin
                    drv_q <= '0;
                    st_q  <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pin_o      = drv_q.lvl;
    assign pin_oe_o   = drv_q.oe;
    assign tx_ready_o = (st_q == ST_IDLE);
    assign rx_bit_o   = rxb_q;
    assign rx_valid_o = rxv_q;
endmodule

// File: rtl/dbg_bit_engine_chk.sv
module dbg_bit_engine_chk (
    input logic clk,
    input logic rst,
    input logic pin_o,
    input logic pin_oe_o,
    input logic tx_valid_i,
    input logic tx_ready_o,
    input logic rx_valid_o
);
    // R4
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe_o && pin_o) |=> !pin_oe_o);

    // R5
    low_ends_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe_o && !pin_o) |=> pin_oe_o);

    // R3
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R7
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_oe_o |-> !pin_o);

    // R2
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |-> !pin_oe_o);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
endmodule

bind dbg_bit_engine dbg_bit_engine_chk u_chk (
    .clk(clk), .rst(rst), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o)
);

// File: tb/dbg_bit_engine_tb.sv
module dbg_bit_engine_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_low = 1'b0;
    logic tx_bit = 1'b0, tx_valid = 1'b0, rx_req = 1'b0;
    logic pin_o, pin_oe, tx_ready, rx_bit, rx_valid;
    wire  pin_i = host_low ? 1'b0 : (pin_oe ? pin_o : 1'b1);

    int checks = 0, fails = 0, cyc = 0;
    int n_low = 0, n_rv = 0, last_rv_cyc = 0;
    bit started = 0;

    always #10 clk = ~clk;

    dbg_bit_engine u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe),
        .tx_bit_i(tx_bit), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .rx_req_i(rx_req), .rx_bit_o(rx_bit), .rx_valid_o(rx_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: time since detected edge
    int  ph = 0, md = 0, k = 0;
    bit  ms0 = 1, ms1 = 1, mp = 1, cap = 0, fall;
    logic e_oe, e_o, e_rv, e_rb, e_rdy;

    function automatic int end_of(input int m);
        return (m == 0) ? 13 : (m == 1) ? 8 : 11;
    endfunction

    always @(posedge clk) begin
        bit pin_now;
        pin_now = pin_i;
        cyc++;
        e_rv = 1'b0;
        if (rst) begin
            ph = 0; md = 0; k = 0; ms0 = 1; ms1 = 1; mp = 1; e_rb = 1'b0;
            started = 1;
        end else begin
            fall = mp && !ms1;
            case (ph)
                0: if (tx_valid) begin ph = 1; md = tx_bit ? 1 : 2; end
                   else if (rx_req) begin ph = 1; md = 0; end
                1: if (fall) begin ph = 2; k = 1; end
                default: begin
                    if (md == 0 && k == 12) cap = ms1;
                    k++;
                    if (k == end_of(md)) begin
                        ph = 0;
                        if (md == 0) begin e_rv = 1'b1; e_rb = cap; end
                    end
                end
            endcase
            mp = ms1; ms1 = ms0; ms0 = pin_now;
        end
        e_rdy = (ph == 0);
        e_oe  = (ph == 2) && ((md == 2 && k <= 10) || (md == 1 && k == 7));
        e_o   = (ph == 2) && ((md == 2 && k == 10) || (md == 1 && k == 7));
        if (cyc > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            string dtag;
            dtag = (md == 1) ? "R4" : (md == 2) ? "R5" : "R7";
            chk(tx_ready === e_rdy, "R2 ready", tx_ready, e_rdy);
            chk(pin_oe === e_oe, {dtag, " oe"}, pin_oe, e_oe);
            chk(pin_o === e_o, {dtag, " level"}, pin_o, e_o);
            chk(rx_valid === e_rv, "R3 valid", rx_valid, e_rv);
            if (e_rv) chk(rx_bit === e_rb, "R3 bit", rx_bit, e_rb);
            if (pin_oe && !pin_o) n_low++;
            if (rx_valid) begin n_rv++; last_rv_cyc = cyc; end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_edge(input int low_cycles);
        host_low = 1'b1; tick(low_cycles); host_low = 1'b0;
    endtask

    task automatic send(input bit b);
        tx_bit = b; tx_valid = 1'b1; tick(1); tx_valid = 1'b0;
    endtask

    task automatic recv_req();
        rx_req = 1'b1; tick(1); rx_req = 1'b0;
    endtask

    initial begin
        int t0, base;
        tick(3);
        rst = 1'b0;
        // R8 reset state
        chk(tx_ready === 1'b1 && pin_oe === 1'b0 && rx_valid === 1'b0 && pin_o === 1'b0,
            "R8 reset", {tx_ready, pin_oe, rx_valid}, 3'b100);
        tick(2);

        // R1 receive of 1, latency from host pull-down
        recv_req(); tick(2);
        t0 = cyc; host_edge(4); tick(20);
        chk(last_rv_cyc - t0 == 15, "R1 latency", last_rv_cyc - t0, 15);

        // R3 receive of 0
        base = n_rv;
        recv_req(); tick(2); host_edge(18); tick(6);
        chk(n_rv - base == 1, "R3 count", n_rv - base, 1);

        // R4 transmit of 1
        send(1'b1); tick(2); host_edge(2); tick(14);

        // R5 transmit of 0 with a second host edge mid-bit (R6)
        base = n_low;
        send(1'b0); tick(2); host_edge(2); tick(3); host_edge(2); tick(14);
        chk(n_low - base == 9, "R6 midbit low count", n_low - base, 9);

        // R6 edge while idle is not latched
        base = n_rv;
        host_edge(3); tick(5);
        recv_req(); tick(25);
        chk(n_rv - base == 0, "R6 idle edge", n_rv - base, 0);
        host_edge(2); tick(20);
        chk(n_rv - base == 1, "R6 armed edge", n_rv - base, 1);

        // R2 priority: both requests together
        base = n_low;
        tx_bit = 1'b0; tx_valid = 1'b1; rx_req = 1'b1; tick(1);
        tx_valid = 1'b0; rx_req = 1'b0; tick(2);
        host_edge(2); tick(16);
        chk(n_low - base == 9, "R2 priority", n_low - base, 9);

        // R8 reset in the middle of a low drive
        send(1'b0); tick(2); host_edge(2); tick(4);
        rst = 1'b1; tick(1); rst = 1'b0;
        chk(pin_oe === 1'b0 && tx_ready === 1'b1, "R8 midbit", {pin_oe, tx_ready}, 2'b01);
        tick(4);

        // back-to-back transmit then receive
        send(1'b1); tick(1); host_edge(1); tick(10);
        recv_req(); tick(1); host_edge(3); tick(18);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule